// File: doc/BRIEF.md
# Memory Operand Offset Generator (32-bit ModRM/SIB)

This block works out the 32-bit effective offset of a memory operand. A start pulse delivers the ModRM byte. The block then pulls any SIB byte and any displacement from a byte-serial instruction stream that uses a valid/ready handshake. It adds the selected registers, taken from an eight-entry general register file, to that displacement.

When the result is ready, a done strobe rises and stays high until the next start. Alongside the offset the block reports:

- how many stream bytes it consumed;
- whether the encoding is illegal for a memory operand;
- whether a write through a CS override was attempted in flat mode.

Prefix decoding, segment translation and the memory access itself belong to neighbouring blocks.

Top module: `modrm_addr_gen`

## Requirements
- R1: The register file input holds slot i in bits [32*i+31:32*i], slots 0..7 being EAX, ECX, EDX, EBX, ESP, EBP, ESI, EDI. With mod (ModRM[7:6]) 0 and r/m (ModRM[2:0]) neither 4 nor 5, the offset is the register selected by r/m. No stream byte is used, and done rises at the first clock edge after start.
- R2: With mod 0 and r/m 5 and no SIB, the offset is a 4-byte displacement alone, with no register added. Displacement bytes arrive least significant first.
- R3: Without SIB, mod 1 adds one displacement byte sign-extended to 32 bits to the r/m register, and mod 2 adds a 4-byte displacement.
- R4: r/m 4 with mod not 3 fetches a SIB byte first, split as scale [7:6], index [5:3] and base [2:0]. The offset is base register + (index register << scale) + displacement, with the displacement chosen by mod as in R3.
- R5: A SIB index of 4 adds no index register. If the scale is also nonzero, the invalid flag is raised with done, and the displacement is still consumed.
- R6: With a SIB byte, mod 0 and base 5 adds no base register and consumes a 4-byte displacement.
- R7: mod 3 raises invalid, uses no stream byte, gives offset 0, and completes at the first edge after start.
- R8: bytes_used equals SIB presence plus displacement length. Stream ready is high only while a byte is awaited. A cycle with valid low consumes nothing.
- R9: done and all results hold until the next start. A start seen while the block is busy is ignored.
- R10: prot_fault rises with done exactly when ModRM bit 4 (write) is set and flat_mode and seg_cs_override were high at start. Otherwise it is low.
- R11: After reset, done, ready, invalid, prot_fault, offset and bytes_used are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new computation (accepted when idle or done) |
| modrm_i | input | 8 | ModRM byte, sampled with start |
| flat_mode_i | input | 1 | Non-segmented mode, sampled with start |
| seg_cs_override_i | input | 1 | Explicit CS segment override, sampled with start |
| regs_i | input | 256 | Eight 32-bit general registers |
| strm_data_i | input | 8 | Instruction stream byte |
| strm_valid_i | input | 1 | Stream byte valid |
| strm_ready_o | output | 1 | Block accepts a stream byte this cycle |
| offset_o | output | 32 | Effective offset |
| bytes_used_o | output | 3 | Stream bytes consumed |
| done_o | output | 1 | Result valid, held until next start |
| invalid_o | output | 1 | Illegal encoding |
| prot_fault_o | output | 1 | Write via CS override in flat mode |

## Verification
The bench targets the SIB escape values, which a careless decoder handles wrongly in predictable ways:

- **Base 5 under mod 0.** A design that treats it as an ordinary base adds EBP and under-fetches the displacement.
- **Index 4.** A design that ignores it adds ESP and misses the nonzero-scale invalid case.
- **Sign extension of the 8-bit displacement.** If this is wrong, a negative displacement becomes a large positive one.

Stalls on the stream and a start pulse during a fetch are also driven. A design that ignores valid would consume garbage. A design that honours a busy start would restart with the wrong ModRM and report a different count.

// File: rtl/modrm_agen_pkg.sv
package modrm_agen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SIB,
        ST_DISP,
        ST_DONE
    } agen_state_e;

    typedef enum logic [1:0] {
        DISP_NONE,
        DISP_BYTE,
        DISP_WORD
    } disp_kind_e;

    typedef struct packed {
        logic       need_sib;
        disp_kind_e disp_kind;
        logic       base_en;
        logic [2:0] base_sel;
        logic       idx_en;
        logic [2:0] idx_sel;
        logic [1:0] scale;
        logic       illegal;
    } ea_fields_t;

endpackage

// File: rtl/ea_decode.sv
module ea_decode
    import modrm_agen_pkg::*;
(
    input  logic [7:0] modrm_i,
    input  logic [7:0] sib_i,
    output ea_fields_t fields_o
);
    logic [1:0] mod_f;
    logic [2:0] rm_f;
    logic [1:0] sc_f;
    logic [2:0] ix_f;
    logic [2:0] bs_f;
    logic       sib_here;
    logic       no_base;

    always_comb begin
        mod_f    = modrm_i[7:6];
        rm_f     = modrm_i[2:0];
        sc_f     = sib_i[7:6];
        ix_f     = sib_i[5:3];
        bs_f     = sib_i[2:0];
        sib_here = (rm_f == 3'd4) && (mod_f != 2'd3);
        no_base  = (mod_f == 2'd0) && (sib_here ? (bs_f == 3'd5) : (rm_f == 3'd5));

        fields_o          = '0;
        fields_o.need_sib = sib_here;
        unique case (mod_f)
            2'd1:    fields_o.disp_kind = DISP_BYTE;
            2'd2:    fields_o.disp_kind = DISP_WORD;
            2'd0:    fields_o.disp_kind = no_base ? DISP_WORD : DISP_NONE;
            default: fields_o.disp_kind = DISP_NONE;
        endcase
        fields_o.base_en  = (mod_f != 2'd3) && !no_base;
        fields_o.base_sel = sib_here ? bs_f : rm_f;
        fields_o.idx_en   = sib_here && (ix_f != 3'd4);
        fields_o.idx_sel  = ix_f;
        fields_o.scale    = sib_here ? sc_f : 2'd0;
        fields_o.illegal  = (mod_f == 2'd3) ||
                            (sib_here && (ix_f == 3'd4) && (sc_f != 2'd0));
    end
endmodule

// File: rtl/ea_sum.sv
module ea_sum
    import modrm_agen_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 8
) (
    input  logic [NREG*XLEN-1:0] regs_i,
    input  ea_fields_t           fields_i,
    input  logic [XLEN-1:0]      disp_i,
    output logic [XLEN-1:0]      offset_o
);
    logic [XLEN-1:0] slot [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign slot[g] = regs_i[g*XLEN +: XLEN];
    end

    logic [XLEN-1:0] base_v;
    logic [XLEN-1:0] idx_v;
    logic [XLEN-1:0] disp_v;

    always_comb begin
        base_v = fields_i.base_en ? slot[fields_i.base_sel] : '0;
        idx_v  = fields_i.idx_en ? (slot[fields_i.idx_sel] << fields_i.scale) : '0;
        unique case (fields_i.disp_kind)
            DISP_BYTE: disp_v = {{(XLEN-8){disp_i[7]}}, disp_i[7:0]};
            DISP_WORD: disp_v = disp_i;
            default:   disp_v = '0;
        endcase
        offset_o = base_v + idx_v + disp_v;
    end
endmodule

// File: rtl/modrm_addr_gen.sv
module modrm_addr_gen
    import modrm_agen_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [7:0]               modrm_i,
    input  logic                     flat_mode_i,
    input  logic                     seg_cs_override_i,
    input  logic [8*XLEN-1:0]        regs_i,
    input  logic [7:0]               strm_data_i,
    input  logic                     strm_valid_i,
    output logic                     strm_ready_o,
    output logic [XLEN-1:0]          offset_o,
    output logic [$clog2(XLEN/8+2)-1:0] bytes_used_o,
    output logic                     done_o,
    output logic                     invalid_o,
    output logic                     prot_fault_o
);
    localparam int NREG       = 8;
    localparam int WORD_BYTES = XLEN / 8;
    localparam int CNT_W      = $clog2(WORD_BYTES + 1);
    localparam int USED_W     = $clog2(WORD_BYTES + 2);

    typedef struct packed {
        agen_state_e       state;
        logic [7:0]        modrm;
        logic [7:0]        sib;
        logic [XLEN-1:0]   disp;
        logic [CNT_W-1:0]  cnt;
        logic [USED_W-1:0] used;
        logic [XLEN-1:0]   offset;
        logic              done;
        logic              invalid;
        logic              pfault;
    } agen_regs_t;

    agen_regs_t q, d;

    logic            can_start;
    logic [7:0]      modrm_cur;
    logic [7:0]      sib_cur;
    logic [XLEN-1:0] disp_cur;
    logic [CNT_W-1:0] len_cur;
    ea_fields_t      fields;
    logic [XLEN-1:0] sum;

    assign can_start = (q.state == ST_IDLE) || (q.state == ST_DONE);
    assign modrm_cur = can_start ? modrm_i : q.modrm;
    assign sib_cur   = (q.state == ST_SIB) ? strm_data_i : q.sib;

    ea_decode u_decode (
        .modrm_i  (modrm_cur),
        .sib_i    (sib_cur),
        .fields_o (fields)
    );

    always_comb begin
        disp_cur = '0;
        if (q.state == ST_DISP) begin
            disp_cur = q.disp;
            for (int i = 0; i < WORD_BYTES; i++) begin
                if (q.cnt == CNT_W'(i)) disp_cur[8*i +: 8] = strm_data_i;
            end
        end
    end

    always_comb begin
        unique case (fields.disp_kind)
            DISP_BYTE: len_cur = CNT_W'(1);
            DISP_WORD: len_cur = CNT_W'(WORD_BYTES);
            default:   len_cur = '0;
        endcase
    end

    ea_sum #(.XLEN(XLEN), .NREG(NREG)) u_sum (
        .regs_i   (regs_i),
        .fields_i (fields),
        .disp_i   (disp_cur),
        .offset_o (sum)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    d.modrm   = modrm_i;
                    d.sib     = '0;
                    d.disp    = '0;
                    d.cnt     = '0;
                    d.used    = '0;
                    d.offset  = '0;
                    d.done    = 1'b0;
                    d.invalid = 1'b0;
                    d.pfault  = modrm_i[4] && flat_mode_i && seg_cs_override_i;
                    if (modrm_i[7:6] == 2'd3) begin
                        d.invalid = 1'b1;
                        d.done    = 1'b1;
                        d.state   = ST_DONE;
                    end else if (fields.need_sib) begin
                        d.state = ST_SIB;
                    end else if (len_cur == '0) begin
                        d.offset  = sum;
                        d.invalid = fields.illegal;
                        d.done    = 1'b1;
                        d.state   = ST_DONE;
                    end else begin
                        d.state = ST_DISP;
                    end
                end
            end
            ST_SIB: begin
                if (strm_valid_i) begin
                    d.sib  = strm_data_i;
                    d.used = q.used + 1'b1;
                    if (len_cur == '0) begin
                        d.offset  = sum;
                        d.invalid = fields.illegal;
                        d.done    = 1'b1;
                        d.state   = ST_DONE;
                    end else begin
                        d.state = ST_DISP;
                    end
                end
            end
            ST_DISP: begin
                if (strm_valid_i) begin
                    d.disp = disp_cur;
                    d.cnt  = q.cnt + 1'b1;
                    d.used = q.used + 1'b1;
                    if (CNT_W'(q.cnt + 1'b1) == len_cur) begin
                        d.offset  = sum;
                        d.invalid = fields.illegal;
                        d.done    = 1'b1;
                        d.state   = ST_DONE;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign strm_ready_o = (q.state == ST_SIB) || (q.state == ST_DISP);
    assign offset_o     = q.offset;
    assign bytes_used_o = q.used;
    assign done_o       = q.done;
    assign invalid_o    = q.done && q.invalid;
    assign prot_fault_o = q.done && q.pfault;

    // R8: a byte is requested only while no result is presented
    p_ready_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        strm_ready_o |-> !done_o);

    // R8: consumed count never exceeds SIB plus longest displacement
    p_used_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (bytes_used_o <= USED_W'(WORD_BYTES + 1)));

    // R9: result holds until a new start
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(offset_o) && $stable(bytes_used_o)));

    // R9: start during a fetch leaves the captured ModRM alone
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (strm_ready_o && start_i && !strm_valid_i) |=> (strm_ready_o && $stable(q.modrm)));

    // R7: register-form mod is flagged and consumes nothing
    p_mod3_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && q.modrm[7:6] == 2'd3) |-> (invalid_o && bytes_used_o == '0));

    // R10: a fault is only ever reported for a write
    p_fault_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault_o |-> (q.modrm[4] && done_o));
endmodule

// File: tb/modrm_addr_gen_tb.sv
module modrm_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  modrm = '0;
    logic        flat = 1'b0;
    logic        csov = 1'b0;
    logic [255:0] regs_flat;
    logic [7:0]  sdata = '0;
    logic        svalid = 1'b0;
    logic        sready;
    logic [31:0] offset;
    logic [2:0]  used;
    logic        done;
    logic        invalid;
    logic        pfault;

    int total = 0;
    int bad = 0;

    logic [31:0] rf [8];
    logic [7:0]  sb [5];

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) regs_flat[32*i +: 32] = rf[i];
    end

    modrm_addr_gen u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .start_i           (start),
        .modrm_i           (modrm),
        .flat_mode_i       (flat),
        .seg_cs_override_i (csov),
        .regs_i            (regs_flat),
        .strm_data_i       (sdata),
        .strm_valid_i      (svalid),
        .strm_ready_o      (sready),
        .offset_o          (offset),
        .bytes_used_o      (used),
        .done_o            (done),
        .invalid_o         (invalid),
        .prot_fault_o      (pfault)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: walk the stream bytes as the encoding rules say.
    task automatic model(input logic [7:0] m, output int need, output logic [31:0] off, output bit inv);
        int mode, rm, k, dl;
        logic [7:0] s;
        logic [31:0] disp, basev, idxv;
        mode = int'(m[7:6]);
        rm   = int'(m[2:0]);
        need = 0; off = 0; inv = 0;
        if (mode == 3) begin
            inv = 1;
            return;
        end
        k = 0; s = 8'h00;
        if (rm == 4) begin
            s = sb[0];
            k = 1;
        end
        if (mode == 1) dl = 1;
        else if (mode == 2) dl = 4;
        else if ((k == 1 && s[2:0] == 3'd5) || (k == 0 && rm == 5)) dl = 4;
        else dl = 0;
        disp = 0;
        for (int j = 0; j < dl; j++) disp = disp | (32'(sb[k+j]) << (8*j));
        if (dl == 1 && sb[k][7]) disp = disp | 32'hFFFF_FF00;
        if (mode == 0 && ((k == 1 && s[2:0] == 3'd5) || (k == 0 && rm == 5))) basev = 0;
        else if (k == 1) basev = rf[s[2:0]];
        else basev = rf[rm];
        idxv = 0;
        if (k == 1 && s[5:3] != 3'd4) idxv = rf[s[5:3]] << s[7:6];
        if (k == 1 && s[5:3] == 3'd4 && s[7:6] != 2'd0) inv = 1;
        need = k + dl;
        off = basev + idxv + disp;
    endtask

    task automatic run_op(input string req, input logic [7:0] m, input logic f, input logic c,
                          input bit stall, input bit poke);
        int need, k, cyc;
        logic [31:0] eoff;
        bit einv;
        model(m, need, eoff, einv);
        @(negedge clk);
        start = 1'b1; modrm = m; flat = f; csov = c; svalid = 1'b0;
        @(negedge clk);
        start = 1'b0; modrm = 8'h00;
        k = 0; cyc = 0;
        while (k < need) begin
            chk("R8", "ready while waiting", 32'(sready), 32'd1);
            chk("R9", "done low while busy", 32'(done), 32'd0);
            if (poke && cyc == 0) begin
                start = 1'b1; modrm = 8'hC0;
            end
            if (stall && (cyc % 2 == 0)) begin
                svalid = 1'b0; sdata = 8'hEE;
            end else begin
                svalid = 1'b1; sdata = sb[k];
            end
            @(negedge clk);
            if (svalid) k++;
            svalid = 1'b0; start = 1'b0; modrm = 8'h00;
            cyc++;
        end
        chk(req, "done", 32'(done), 32'd1);
        chk("R8", "ready after done", 32'(sready), 32'd0);
        chk(req, "offset", offset, eoff);
        chk("R8", "bytes used", 32'(used), 32'(need));
        chk(req, "invalid", 32'(invalid), 32'(einv));
        chk("R10", "prot fault", 32'(pfault), 32'(m[4] & f & c));
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] hold_off;
        rf[0] = 32'h0000_1000; rf[1] = 32'h0000_2000; rf[2] = 32'h0003_0000;
        rf[3] = 32'h0040_0000; rf[4] = 32'h0500_0000; rf[5] = 32'h6000_0000;
        rf[6] = 32'h0000_0070; rf[7] = 32'h0000_0008;
        for (int i = 0; i < 5; i++) sb[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R11", "done", 32'(done), 0);
        chk("R11", "ready", 32'(sready), 0);
        chk("R11", "offset", offset, 0);
        chk("R11", "used", 32'(used), 0);
        chk("R11", "flags", 32'({invalid, pfault}), 0);
        rst_n = 1'b1;

        // R1: register only
        run_op("R1", 8'h03, 0, 0, 0, 0);
        run_op("R1", 8'h07, 0, 0, 0, 0);
        // R2: absolute displacement, with stalls
        sb[0] = 8'h78; sb[1] = 8'h56; sb[2] = 8'h34; sb[3] = 8'h12;
        run_op("R2", 8'h05, 0, 0, 1, 0);
        // R3: negative byte displacement, then word displacement
        sb[0] = 8'hF0;
        run_op("R3", 8'h41, 0, 0, 0, 0);
        sb[0] = 8'h01; sb[1] = 8'h02; sb[2] = 8'h03; sb[3] = 8'h84;
        run_op("R3", 8'h86, 0, 0, 0, 1);
        // R9: result held while start stays low
        hold_off = offset;
        repeat (3) begin
            @(negedge clk);
            chk("R9", "done held", 32'(done), 1);
            chk("R9", "offset held", offset, hold_off);
        end
        // R4: scaled index with byte displacement
        sb[0] = 8'h8B; sb[1] = 8'h10;
        run_op("R4", 8'h44, 0, 0, 1, 0);
        sb[0] = 8'hF8;
        run_op("R4", 8'h04, 0, 0, 0, 0);
        // R5: no index with nonzero scale flags invalid
        sb[0] = 8'hE2; sb[1] = 8'h04; sb[2] = 8'h00; sb[3] = 8'h00; sb[4] = 8'h00;
        run_op("R5", 8'h84, 0, 0, 0, 0);
        sb[0] = 8'h22; sb[1] = 8'h7F;
        run_op("R5", 8'h44, 0, 0, 0, 0);
        // R6: no base under mod 0
        sb[0] = 8'h25; sb[1] = 8'hAA; sb[2] = 8'hBB; sb[3] = 8'hCC; sb[4] = 8'h0D;
        run_op("R6", 8'h04, 0, 0, 0, 0);
        sb[0] = 8'h4D;
        run_op("R6", 8'h04, 0, 0, 1, 0);
        // R7: register form
        run_op("R7", 8'hC0, 0, 0, 0, 0);
        run_op("R7", 8'hD7, 1, 1, 0, 0);
        // R10: write through CS in flat mode
        run_op("R10", 8'h13, 1, 1, 0, 0);
        run_op("R10", 8'h13, 0, 1, 0, 0);
        run_op("R10", 8'h03, 1, 1, 0, 0);
        run_op("R10", 8'h13, 1, 0, 0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule